// File: doc/BRIEF.md
# Integer shift and arithmetic unit

This block executes integer data-processing instructions on a private file of sixteen 64-bit registers. Each instruction is presented on `instr_i` with a one-cycle `issue_i` strobe. It is decoded, and its operands are read from the file. The result is written back to the destination register on the next clock edge, and `done_o` pulses for that one cycle. A 32-bit integer occupies the lower half of a register. Every 32-bit operation leaves the upper half of its destination untouched.

A two-bit group field selects one of four operation classes:
- an immediate shift of the low word;
- multiply and multiply-accumulate;
- an immediate shift of the full register;
- absolute value, negate, add and subtract in both widths.

The shift amount is a 7-bit signed immediate assembled from two separate instruction fields. Its sign picks the direction. Those same bits serve as the sub-operation select in the arithmetic groups.

The register file is filled through a simple load port, which is normally driven by the host transfer path. After each issue, the written register value and its index are presented on `wb_data_o` and `wb_idx_o`.

Top module: `coproc_int_alu_top`

## Requirements
- R1: Field positions in the instruction word are fixed: the group is bits 21:20, the destination register is bits 15:12, the first source is bits 19:16, the second source is bits 3:0 and the sub-operation select is bits 7:5. `wb_idx_o` reports the destination index after each issue.
- R2: The shift amount is the 7-bit value {bits 7:5, bits 3:0}. Bit 6 of that value is its sign, so it ranges from -64 to +63. A shift of 0 copies the source unchanged.
- R3: In group 0 (low-word shift) and group 2 (full-register shift), a positive amount shifts left and a negative amount shifts right arithmetically by its magnitude. A left shift of at least the operand width gives 0. A right shift of at least the operand width gives all sign bits.
- R4: Every 32-bit operation writes only the lower 32 bits of the destination. The upper 32 bits keep their previous value.
- R5: In group 1, sub-operation 0 is a 32-bit multiply, 1 is a 64-bit multiply, 2 is dest_lo += a_lo*b_lo and 3 is dest_lo -= a_lo*b_lo.
- R6: In group 3, sub-operations 0 through 7 are, in order: abs32, abs64, neg32, neg64, add32, add64, sub32 and sub64.
- R7: All results wrap modulo 2^32 or 2^64. A multiply keeps only the low half of the product, and the absolute value of the most negative number is that number itself.
- R8: A result is written on the clock edge after issue, and `done_o` is high for exactly the cycle after each issued cycle. Back-to-back issues are allowed, and a dependent instruction sees the preceding result.
- R9: Group 1 sub-operations 4 to 7 are illegal. They raise `illegal_o` together with `done_o`, write nothing, and report the unchanged destination value on `wb_data_o`.
- R10: When `issue_i` is low, `ld_en_i` writes `ld_data_i` to register `ld_idx_i`. A load presented in the same cycle as an issue is dropped.
- R11: After reset, all registers hold 0, `done_o` and `illegal_o` are 0, and `wb_idx_o` and `wb_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction valid strobe |
| instr_i | input | 32 | Instruction word |
| ld_en_i | input | 1 | Register load enable |
| ld_idx_i | input | 4 | Register index to load |
| ld_data_i | input | 64 | Value to load |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Illegal instruction, valid with done_o |
| wb_idx_o | output | 4 | Destination index of the completed instruction |
| wb_data_o | output | 64 | Destination register value after completion |

## Verification
Several properties are checked on every cycle: the issue-to-done timing, the destination index, preservation of the upper half on every 32-bit operation, the illegal-select response with an unchanged destination, and pass-through on a zero shift. The following can only be shown by the bench's scenarios against its behavioural model:
- the arithmetic values themselves: both shift directions at their extremes, wrapping of products and negation of the most negative values;
- the ordering of the sub-operation selects;
- a dependent back-to-back pair;
- the dropped load that collides with an issue.

// File: rtl/coproc_int_pkg.sv
package coproc_int_pkg;
  localparam int REG_AW   = 4;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int SH_W     = 7;

  // bit positions decoded by the instruction source
  localparam int GRP_LSB = 20;
  localparam int RS1_LSB = 16;
  localparam int RD_LSB  = 12;
  localparam int OP2_LSB = 5;
  localparam int RS2_LSB = 0;

  typedef enum logic [1:0] {
    GRP_SH_LO  = 2'd0,
    GRP_MULT   = 2'd1,
    GRP_SH_W   = 2'd2,
    GRP_UNARY  = 2'd3
  } grp_e;

  localparam logic [2:0] MOP_MUL_LO = 3'd0;
  localparam logic [2:0] MOP_MUL_W  = 3'd1;
  localparam logic [2:0] MOP_MAC_LO = 3'd2;
  localparam logic [2:0] MOP_MSC_LO = 3'd3;

  localparam logic [2:0] AOP_ABS_LO = 3'd0;
  localparam logic [2:0] AOP_ABS_W  = 3'd1;
  localparam logic [2:0] AOP_NEG_LO = 3'd2;
  localparam logic [2:0] AOP_NEG_W  = 3'd3;
  localparam logic [2:0] AOP_ADD_LO = 3'd4;
  localparam logic [2:0] AOP_ADD_W  = 3'd5;
  localparam logic [2:0] AOP_SUB_LO = 3'd6;
  localparam logic [2:0] AOP_SUB_W  = 3'd7;

  typedef struct packed {
    grp_e                   grp;
    logic [2:0]             op2;
    logic [REG_AW-1:0]      rd;
    logic [REG_AW-1:0]      rs1;
    logic [REG_AW-1:0]      rs2;
    logic signed [SH_W-1:0] shamt;
  } dec_t;
endpackage

// File: rtl/coproc_int_decode.sv
module coproc_int_decode
  import coproc_int_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic unused_bits;
  assign unused_bits = ^{instr_i[31:22], instr_i[11:8], instr_i[4]};

  always_comb begin
    dec_o.grp   = grp_e'(instr_i[GRP_LSB +: 2]);
    dec_o.op2   = instr_i[OP2_LSB +: 3];
    dec_o.rd    = instr_i[RD_LSB +: REG_AW];
    dec_o.rs1   = instr_i[RS1_LSB +: REG_AW];
    dec_o.rs2   = instr_i[RS2_LSB +: REG_AW];
    // split immediate: high three bits from op2 field, low nibble from rs2 field
    dec_o.shamt = {instr_i[OP2_LSB +: 3], instr_i[RS2_LSB +: 4]};
  end
endmodule

// File: rtl/coproc_int_regfile.sv
module coproc_int_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  input  logic [AW-1:0]     raddr_d_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [DATA_W-1:0] rdata_d_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign rdata_d_o = regs_q[raddr_d_i];
endmodule

// File: rtl/coproc_int_alu.sv
module coproc_int_alu
  import coproc_int_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] res_o,
  output logic              illegal_o
);
  logic [HALF_W-1:0] a_lo, b_lo, d_lo, d_hi;
  assign a_lo = a_i[HALF_W-1:0];
  assign b_lo = b_i[HALF_W-1:0];
  assign d_lo = d_i[HALF_W-1:0];
  assign d_hi = d_i[DATA_W-1:HALF_W];

  // shift magnitude; -64 maps to 64 in unsigned 7 bits
  logic            sh_right;
  logic [SH_W-1:0] sh_mag;
  assign sh_right = dec_i.shamt[SH_W-1];
  assign sh_mag   = sh_right ? SH_W'(-dec_i.shamt) : SH_W'(dec_i.shamt);

  logic signed [HALF_W-1:0] sra_lo;
  logic signed [DATA_W-1:0] sra_w;
  logic [HALF_W-1:0]        sll_lo, sh_lo;
  logic [DATA_W-1:0]        sll_w, sh_w;
  assign sra_lo = $signed(a_lo) >>> sh_mag;
  assign sll_lo = a_lo << sh_mag;
  assign sra_w  = $signed(a_i) >>> sh_mag;
  assign sll_w  = a_i << sh_mag;
  assign sh_lo  = sh_right ? sra_lo : sll_lo;
  assign sh_w   = sh_right ? sra_w : sll_w;

  logic [HALF_W-1:0] mul_lo;
  logic [DATA_W-1:0] mul_w;
  assign mul_lo = a_lo * b_lo;
  assign mul_w  = a_i * b_i;

  logic [HALF_W-1:0] neg_lo;
  logic [DATA_W-1:0] neg_w;
  assign neg_lo = -a_lo;
  assign neg_w  = -a_i;

  always_comb begin
    res_o     = d_i;
    illegal_o = 1'b0;
    unique case (dec_i.grp)
      GRP_SH_LO: res_o = {d_hi, sh_lo};
      GRP_SH_W:  res_o = sh_w;
      GRP_MULT: begin
        case (dec_i.op2)
          MOP_MUL_LO: res_o = {d_hi, mul_lo};
          MOP_MUL_W:  res_o = mul_w;
          MOP_MAC_LO: res_o = {d_hi, d_lo + mul_lo};
          MOP_MSC_LO: res_o = {d_hi, d_lo - mul_lo};
          default:    illegal_o = 1'b1;
        endcase
      end
      GRP_UNARY: begin
        case (dec_i.op2)
          AOP_ABS_LO: res_o = {d_hi, a_lo[HALF_W-1] ? neg_lo : a_lo};
          AOP_ABS_W:  res_o = a_i[DATA_W-1] ? neg_w : a_i;
          AOP_NEG_LO: res_o = {d_hi, neg_lo};
          AOP_NEG_W:  res_o = neg_w;
          AOP_ADD_LO: res_o = {d_hi, a_lo + b_lo};
          AOP_ADD_W:  res_o = a_i + b_i;
          AOP_SUB_LO: res_o = {d_hi, a_lo - b_lo};
          default:    res_o = a_i - b_i;
        endcase
      end
      default: res_o = d_i;
    endcase
  end
endmodule

// File: rtl/coproc_int_alu_top.sv
module coproc_int_alu_top
  import coproc_int_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [31:0]       instr_i,
  input  logic              ld_en_i,
  input  logic [REG_AW-1:0] ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [REG_AW-1:0] wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  dec_t              dec;
  logic [DATA_W-1:0] rs1_data, rs2_data, rd_data, alu_res;
  logic              alu_illegal;
  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  coproc_int_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  coproc_int_regfile #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (dec.rs1),
    .raddr_b_i (dec.rs2),
    .raddr_d_i (dec.rd),
    .rdata_a_o (rs1_data),
    .rdata_b_o (rs2_data),
    .rdata_d_o (rd_data)
  );

  coproc_int_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .dec_i     (dec),
    .a_i       (rs1_data),
    .b_i       (rs2_data),
    .d_i       (rd_data),
    .res_o     (alu_res),
    .illegal_o (alu_illegal)
  );

  // issue owns the write port; a colliding load is dropped
  assign rf_we    = issue_i ? !alu_illegal : ld_en_i;
  assign rf_waddr = issue_i ? dec.rd : ld_idx_i;
  assign rf_wdata = issue_i ? alu_res : ld_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      done_o    <= issue_i;
      illegal_o <= issue_i && alu_illegal;
      if (issue_i) begin
        wb_idx_o  <= dec.rd;
        wb_data_o <= alu_illegal ? rd_data : alu_res;
      end
    end
  end
endmodule

// File: rtl/coproc_int_chk.sv
module coproc_int_chk #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic [31:0]       instr_i,
  input logic              done_o,
  input logic              illegal_o,
  input logic [3:0]        wb_idx_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic [DATA_W-1:0] rs1_data,
  input logic [DATA_W-1:0] rd_data
);
  logic [1:0] grp;
  logic [2:0] op2;
  logic       bad_sel, lo_only, zero_sh;
  assign grp     = instr_i[21:20];
  assign op2     = instr_i[7:5];
  assign bad_sel = (grp == 2'd1) && op2[2];
  assign lo_only = (grp == 2'd0) || ((grp == 2'd3) && !op2[0]) ||
                   ((grp == 2'd1) && (op2 == 3'd0 || op2 == 3'd2 || op2 == 3'd3));
  assign zero_sh = (grp == 2'd0) && ({op2, instr_i[3:0]} == 7'd0);

  p_done_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !done_o);
  p_wb_index_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> wb_idx_o == $past(instr_i[15:12]));
  p_upper_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && lo_only |=> wb_data_o[DATA_W-1:HALF_W] == $past(rd_data[DATA_W-1:HALF_W]));
  p_illegal_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && bad_sel |=> illegal_o && wb_data_o == $past(rd_data));
  p_legal_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !bad_sel |=> !illegal_o);
  p_zero_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && zero_sh |=> wb_data_o[HALF_W-1:0] == $past(rs1_data[HALF_W-1:0]));
endmodule

bind coproc_int_alu_top coproc_int_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .issue_i   (issue_i),
  .instr_i   (instr_i),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .wb_idx_o  (wb_idx_o),
  .wb_data_o (wb_data_o),
  .rs1_data  (rs1_data),
  .rd_data   (rd_data)
);

// File: tb/coproc_int_alu_tb_top.sv
`timescale 1ns/1ps
module coproc_int_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        ld_en_i = 1'b0;
  logic [3:0]  ld_idx_i = '0;
  logic [63:0] ld_data_i = '0;
  logic        done_o, illegal_o;
  logic [3:0]  wb_idx_o;
  logic [63:0] wb_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] m_reg [16];
  logic exp_done;

  always #10 clk_i = ~clk_i;

  coproc_int_alu_top dut_i (
    .clk_i, .rst_ni, .issue_i, .instr_i, .ld_en_i, .ld_idx_i, .ld_data_i,
    .done_o, .illegal_o, .wb_idx_o, .wb_data_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: done expected exactly one cycle after each issued cycle
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) exp_done <= 1'b0; else exp_done <= issue_i;
  always @(negedge clk_i)
    if (rst_ni) chk("R8 done timing", 64'(done_o), 64'(exp_done));

  function automatic logic [31:0] mk(input logic [1:0] g, input logic [2:0] o,
                                     input logic [3:0] d, input logic [3:0] s1,
                                     input logic [3:0] s2);
    return {10'b0, g, s1, d, 4'b0, o, 1'b0, s2};
  endfunction

  function automatic logic [31:0] mk_sh(input logic [1:0] g, input logic [3:0] d,
                                        input logic [3:0] s1, input int amt);
    logic [6:0] a7;
    a7 = amt[6:0];
    return mk(g, a7[6:4], d, s1, a7[3:0]);
  endfunction

  // behavioural reference
  function automatic logic [63:0] ref_res(input logic [31:0] ins, output logic ill);
    logic [63:0] a, b, d, r;
    logic [31:0] lo;
    logic signed [6:0] amt;
    int n;
    a = m_reg[ins[19:16]];
    b = m_reg[ins[3:0]];
    d = m_reg[ins[15:12]];
    amt = {ins[7:5], ins[3:0]};
    n = amt;
    ill = 1'b0;
    r = d;
    case (ins[21:20])
      2'd0: begin
        if (n >= 0) lo = a[31:0] << n;
        else lo = $signed(a[31:0]) >>> (-n);
        r = {d[63:32], lo};
      end
      2'd2: begin
        if (n >= 0) r = a << n;
        else r = $signed(a) >>> (-n);
      end
      2'd1: begin
        case (ins[7:5])
          3'd0: begin lo = a[31:0] * b[31:0]; r = {d[63:32], lo}; end
          3'd1: r = a * b;
          3'd2: begin lo = d[31:0] + a[31:0] * b[31:0]; r = {d[63:32], lo}; end
          3'd3: begin lo = d[31:0] - a[31:0] * b[31:0]; r = {d[63:32], lo}; end
          default: ill = 1'b1;
        endcase
      end
      default: begin
        case (ins[7:5])
          3'd0: begin lo = a[31] ? -a[31:0] : a[31:0]; r = {d[63:32], lo}; end
          3'd1: r = a[63] ? -a : a;
          3'd2: begin lo = -a[31:0]; r = {d[63:32], lo}; end
          3'd3: r = -a;
          3'd4: begin lo = a[31:0] + b[31:0]; r = {d[63:32], lo}; end
          3'd5: r = a + b;
          3'd6: begin lo = a[31:0] - b[31:0]; r = {d[63:32], lo}; end
          default: r = a - b;
        endcase
      end
    endcase
    return r;
  endfunction

  task automatic ld(input logic [3:0] idx, input logic [63:0] val);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = val;
    @(negedge clk_i);
    ld_en_i = 1'b0;
    m_reg[idx] = val;
  endtask

  task automatic check_wb(input string req, input logic [31:0] ins,
                          input logic [63:0] exp, input logic ill);
    chk({req, " done"}, 64'(done_o), 64'd1);
    chk({req, " R9 illegal flag"}, 64'(illegal_o), 64'(ill));
    chk({req, " R1 wb index"}, 64'(wb_idx_o), 64'(ins[15:12]));
    chk({req, " result"}, wb_data_o, exp);
    if (!ill) m_reg[ins[15:12]] = exp;
  endtask

  task automatic run(input string req, input logic [31:0] ins);
    logic [63:0] e;
    logic il;
    @(negedge clk_i);
    issue_i = 1'b1; instr_i = ins;
    e = ref_res(ins, il);
    @(negedge clk_i);
    issue_i = 1'b0;
    check_wb(req, ins, e, il);
  endtask

  task automatic run2(input string req, input logic [31:0] i1, input logic [31:0] i2);
    logic [63:0] e;
    logic il;
    @(negedge clk_i);
    issue_i = 1'b1; instr_i = i1;
    e = ref_res(i1, il);
    @(negedge clk_i);
    check_wb(req, i1, e, il);
    instr_i = i2;
    e = ref_res(i2, il);
    @(negedge clk_i);
    issue_i = 1'b0;
    check_wb(req, i2, e, il);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 done after reset", 64'(done_o), 64'd0);
    chk("R11 illegal after reset", 64'(illegal_o), 64'd0);
    chk("R11 wb_idx after reset", 64'(wb_idx_o), 64'd0);
    chk("R11 wb_data after reset", wb_data_o, 64'd0);
    run("R11 register zero after reset", mk_sh(2'd2, 4'd9, 4'd7, 0));

    // R10 loads
    ld(4'd1, 64'h1234_5678_F000_000F);
    ld(4'd2, 64'hFFFF_FFFF_FFFF_FFFD);
    ld(4'd3, 64'h8000_0000_8000_0000);
    ld(4'd4, 64'h0000_0001_7FFF_FFFF);
    ld(4'd5, 64'hCAFE_0000_0000_0010);
    ld(4'd6, 64'hA5A5_A5A5_0000_0003);
    run("R10 load readback", mk_sh(2'd2, 4'd10, 4'd1, 0));

    // R2 R3 R4 low-word shifts
    run("R2 zero shift lo", mk_sh(2'd0, 4'd7, 4'd1, 0));
    run("R3 shl lo 4", mk_sh(2'd0, 4'd7, 4'd1, 4));
    run("R3 sra lo 3 negative", mk_sh(2'd0, 4'd7, 4'd1, -3));
    run("R3 shl lo 31", mk_sh(2'd0, 4'd8, 4'd4, 31));
    run("R3 shl lo 40 gives zero", mk_sh(2'd0, 4'd8, 4'd4, 40));
    run("R3 sra lo 64 sign fill", mk_sh(2'd0, 4'd8, 4'd3, -64));
    run("R4 sra lo 31 upper kept", mk_sh(2'd0, 4'd6, 4'd3, -31));
    run("R2 shl lo 63 max positive", mk_sh(2'd0, 4'd8, 4'd1, 63));
    // R3 full-width shifts
    run("R3 shl w 1", mk_sh(2'd2, 4'd11, 4'd1, 1));
    run("R3 shl w 63", mk_sh(2'd2, 4'd11, 4'd5, 63));
    run("R3 sra w 1", mk_sh(2'd2, 4'd11, 4'd2, -1));
    run("R3 sra w 40", mk_sh(2'd2, 4'd11, 4'd3, -40));
    run("R3 sra w 64", mk_sh(2'd2, 4'd11, 4'd3, -64));

    // R5 R7 multiply group
    run("R5 mul32", mk(2'd1, 3'd0, 4'd12, 4'd1, 4'd4));
    run("R5 R7 mul64 wrap", mk(2'd1, 3'd1, 4'd12, 4'd1, 4'd2));
    run("R5 mac32", mk(2'd1, 3'd2, 4'd6, 4'd4, 4'd5));
    run("R5 msc32", mk(2'd1, 3'd3, 4'd6, 4'd1, 4'd2));
    run("R7 mul32 wrap", mk(2'd1, 3'd0, 4'd13, 4'd4, 4'd4));
    // R9 illegal selects
    for (int o = 4; o < 8; o++)
      run("R9 illegal select", mk(2'd1, 3'(o), 4'd6, 4'd1, 4'd2));
    run("R9 dest unchanged after illegal", mk_sh(2'd2, 4'd14, 4'd6, 0));

    // R6 group 3 in order, with extremes for R7
    for (int o = 0; o < 8; o++)
      run("R6 arith op", mk(2'd3, 3'(o), 4'd15, 4'd2, 4'd4));
    run("R7 abs32 most negative", mk(2'd3, 3'd0, 4'd14, 4'd3, 4'd0));
    ld(4'd7, 64'h8000_0000_0000_0000);
    run("R7 abs64 most negative", mk(2'd3, 3'd1, 4'd14, 4'd7, 4'd0));
    run("R7 add32 wrap", mk(2'd3, 3'd4, 4'd14, 4'd4, 4'd4));
    run("R7 sub64 wrap", mk(2'd3, 3'd7, 4'd14, 4'd0, 4'd6));

    // R8 back-to-back dependent
    run2("R8 back-to-back", mk(2'd3, 3'd5, 4'd9, 4'd1, 4'd5),
                            mk(2'd3, 3'd5, 4'd9, 4'd9, 4'd9));

    // R10 load colliding with issue is dropped
    @(negedge clk_i);
    issue_i = 1'b1; instr_i = mk(2'd3, 3'd4, 4'd8, 4'd1, 4'd1);
    ld_en_i = 1'b1; ld_idx_i = 4'd5; ld_data_i = 64'h0BAD_0BAD_0BAD_0BAD;
    begin
      logic [63:0] e;
      logic il;
      e = ref_res(instr_i, il);
      @(negedge clk_i);
      issue_i = 1'b0; ld_en_i = 1'b0;
      check_wb("R10 issue with load", mk(2'd3, 3'd4, 4'd8, 4'd1, 4'd1), e, il);
    end
    run("R10 dropped load readback", mk_sh(2'd2, 4'd14, 4'd5, 0));

    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule